// File: doc/BRIEF.md
# Full-FIFO Deadlock Timeout Terminator

A bus master that is draining a read burst into a FIFO can stall forever when the user side stops popping words. The FIFO stays full, so the master keeps inserting wait states. The target keeps its ready line asserted, so it never ends the transfer either. This block watches the active-low full flag in the bus clock domain and times how long the FIFO has been full without a break. When that time reaches a fixed limit, the block asserts an active-low stop-burst request toward the bus core. It holds that request until the core reports that the transaction has been torn down.

The same timeout event is carried into the user clock domain with a toggle handshake. There it produces one single-cycle extra-read strobe, which pops one word so the core can complete the burst. The strobe is only issued if the FIFO still looks full in the user domain when the decision is made. After the core signals completion, the request is released and the timer is re-armed for a later stall.

Top module: `fifo_stall_breaker`

## Requirements
- R1: While either reset is low and after it is released, `stop_n` is 1 and `pop_x` is 0 until a timeout occurs.
- R2: A run of fewer than TMO = 2**CNT_W consecutive bus-clock samples with `full_n` = 0 causes no stop request and no extra read. Any sample with `full_n` = 1 restarts the count from zero.
- R3: `stop_n` falls right after the bus-clock edge that samples `full_n` = 0 for the TMO-th consecutive time. It is still 1 after the edge before that one.
- R4: Once low, `stop_n` stays low whatever `full_n` does, until `term_done` is sampled at 1.
- R5: A bus-clock edge that samples `term_done` = 1 while `stop_n` is low drives `stop_n` back to 1. The timer restarts from zero at that edge, so a further TMO full samples raise the request again.
- R6: `term_done` sampled while `stop_n` is 1 has no effect. A later full run still times out after exactly TMO samples.
- R7: Each timeout produces exactly one `pop_x` pulse, one user-clock cycle wide, within SYNC_STAGES+4 user-clock cycles after `stop_n` falls.
- R8: If `full_n` returns to 1 within one user-clock period after `stop_n` falls, the extra read is withheld and `pop_x` stays 0 for that timeout.
- R9: A stop request held for any length of time yields no second `pop_x` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Synchronous active-low reset, bus domain |
| uclk | input | 1 | User clock |
| urst_n | input | 1 | Synchronous active-low reset, user domain |
| full_n | input | 1 | Read FIFO full flag, 0 = full (bus domain) |
| term_done | input | 1 | Core reports the aborted transaction has ended (bus domain) |
| stop_n | output | 1 | Stop-burst request to the bus core, 0 = stop |
| pop_x | output | 1 | Single-cycle extra FIFO read strobe (user domain) |

## Verification
The hardest condition to reach is the suppressed extra read. In that case the FIFO drains between the timeout and the user-side decision, and two crossings of different clocks must land in a known order. The stimulus holds the full flag low for exactly the timeout length. It then raises the flag on the bus-clock falling edge right after `stop_n` is seen low, which is well inside one user-clock period. The user-side decision stage waits one extra cycle, so the drained flag is always visible there. The bench also shows the boundary exactly: a run one sample short of the limit, and a run broken by one not-full sample, leave the request untouched.

// File: rtl/stall_pkg.sv
// Package: shared types for the full-FIFO stall breaker.
// Assumes: nothing; holds only the controller state encoding.
package stall_pkg;

    // Controller state: armed and timing, or holding a stop request.
    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_STOP  = 1'b1
    } brk_state_e;

endpackage : stall_pkg

// File: rtl/stall_bit_sync.sv
// Module: stall_bit_sync
// Multi-flop synchronizer for one quasi-static bit into the clk domain.
// Assumes: STAGES >= 2; the input changes slowly against clk.
module stall_bit_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule : stall_bit_sync

// File: rtl/full_run_timer.sv
// Module: full_run_timer
// Counts consecutive bus clocks with the FIFO full while armed. It raises
// ovf in the cycle that would carry out of the top count.
// Assumes: full_n is synchronous to clk; the counter is cleared whenever
// the FIFO is not full or the timer is not armed.
module full_run_timer #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic full_n,
    input  logic arm,
    output logic ovf
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;

    // Full flag acts as clock enable; not-full or disarmed clears.
    always_ff @(posedge clk) begin
        if (!rst_n || full_n || !arm) cnt <= '0;
        else                          cnt <= cnt + 1'b1;
    end

    assign ovf = arm && !full_n && (cnt == CNT_MAX);

endmodule : full_run_timer

// File: rtl/stop_req_ctrl.sv
// Module: stop_req_ctrl
// Holds the stop-burst request from a timeout until the core reports
// termination, and flips an event toggle once per timeout.
// Assumes: ovf and term_done are synchronous to clk.
module stop_req_ctrl
    import stall_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic term_done,
    output logic stop_n,
    output logic armed,
    output logic evt_tgl
);

    brk_state_e state;

    // Advance the armed/stop state and flip the toggle on each timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_ARMED;
            evt_tgl <= 1'b0;
        end else begin
            case (state)
                ST_ARMED: if (ovf) begin
                    state   <= ST_STOP;
                    evt_tgl <= ~evt_tgl;
                end
                ST_STOP:  if (term_done) state <= ST_ARMED;
                default:  state <= ST_ARMED;
            endcase
        end
    end

    assign stop_n = (state != ST_STOP);
    assign armed  = (state == ST_ARMED);

endmodule : stop_req_ctrl

// File: rtl/evt_pop_xfer.sv
// Module: evt_pop_xfer
// Turns each toggle of the bus-domain event into one user-clock pop strobe.
// The strobe is gated by the synchronized full flag, which is checked one
// user cycle after the event is seen.
// Assumes: toggles are spaced further apart than the synchronizer latency.
// A full flag that drops within one user period of the toggle is seen in
// time to gate the strobe.
module evt_pop_xfer #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_tgl,
    input  logic full_n,
    output logic pop_x
);

    logic tgl_s;
    logic full_s_n;
    logic tgl_seen;
    logic evt_hit;
    logic pend;
    logic pop_q;

    stall_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_tgl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (evt_tgl),
        .q     (tgl_s)
    );

    stall_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_full_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (full_n),
        .q     (full_s_n)
    );

    assign evt_hit = tgl_s ^ tgl_seen;

    // Detect the toggle edge, wait one cycle, then pop only if still full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgl_seen <= 1'b0;
            pend     <= 1'b0;
            pop_q    <= 1'b0;
        end else begin
            tgl_seen <= tgl_s;
            pend     <= evt_hit;
            pop_q    <= pend && !full_s_n;
        end
    end

    assign pop_x = pop_q;

endmodule : evt_pop_xfer

// File: rtl/fifo_stall_breaker.sv
// Module: fifo_stall_breaker (top)
// Full-FIFO deadlock timeout terminator. A full run of 2**CNT_W bus clocks
// raises stop_n low until term_done. One extra FIFO pop is issued in the
// user clock domain.
// Assumes: full_n and term_done are bus-clock synchronous; each reset is
// synchronous to its own clock.
module fifo_stall_breaker #(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic bclk,
    input  logic brst_n,
    input  logic uclk,
    input  logic urst_n,
    input  logic full_n,
    input  logic term_done,
    output logic stop_n,
    output logic pop_x
);

    logic ovf;
    logic armed;
    logic evt_tgl;

    full_run_timer #(.CNT_W(CNT_W)) i_timer (
        .clk    (bclk),
        .rst_n  (brst_n),
        .full_n (full_n),
        .arm    (armed),
        .ovf    (ovf)
    );

    stop_req_ctrl i_ctrl (
        .clk       (bclk),
        .rst_n     (brst_n),
        .ovf       (ovf),
        .term_done (term_done),
        .stop_n    (stop_n),
        .armed     (armed),
        .evt_tgl   (evt_tgl)
    );

    evt_pop_xfer #(.SYNC_STAGES(SYNC_STAGES)) i_xfer (
        .clk     (uclk),
        .rst_n   (urst_n),
        .evt_tgl (evt_tgl),
        .full_n  (full_n),
        .pop_x   (pop_x)
    );

endmodule : fifo_stall_breaker

// File: rtl/fifo_stall_breaker_chk.sv
// Module: fifo_stall_breaker_chk
// Port-level checker bound to fifo_stall_breaker. It tracks the run of
// full samples on its own to check the timeout edge.
module fifo_stall_breaker_chk #(
    parameter int CNT_W = 4
) (
    input logic bclk,
    input logic brst_n,
    input logic uclk,
    input logic urst_n,
    input logic full_n,
    input logic term_done,
    input logic stop_n,
    input logic pop_x
);

    localparam int TMO = 1 << CNT_W;

    logic [CNT_W:0] run;

    // Consecutive full samples seen while no request is held (saturating).
    always_ff @(posedge bclk) begin
        if (!brst_n || full_n || !stop_n) run <= '0;
        else if (run != {(CNT_W+1){1'b1}}) run <= run + 1'b1;
    end

    // R1: reset leaves the request deasserted
    a_r1_reset_idle: assert property (@(posedge bclk) !brst_n |=> stop_n);

    // R3: request falls only on the TMO-th full sample
    a_r3_fall_at_limit: assert property (@(posedge bclk) disable iff (!brst_n)
        $fell(stop_n) |-> ($past(run) == (CNT_W+1)'(TMO-1)) && !$past(full_n));

    // R2/R3: reaching the limit while full always raises the request
    a_r3_limit_fires: assert property (@(posedge bclk) disable iff (!brst_n)
        (stop_n && !full_n && run == (CNT_W+1)'(TMO-1)) |=> !stop_n);

    // R4: request held until termination
    a_r4_hold: assert property (@(posedge bclk) disable iff (!brst_n)
        (!stop_n && !term_done) |=> !stop_n);

    // R5: termination releases the request
    a_r5_release: assert property (@(posedge bclk) disable iff (!brst_n)
        (!stop_n && term_done) |=> stop_n);

    // R7: extra read strobe is one user cycle wide
    a_r7_single_cycle: assert property (@(posedge uclk) disable iff (!urst_n)
        pop_x |=> !pop_x);

endmodule : fifo_stall_breaker_chk

bind fifo_stall_breaker fifo_stall_breaker_chk #(.CNT_W(CNT_W)) i_chk (
    .bclk      (bclk),
    .brst_n    (brst_n),
    .uclk      (uclk),
    .urst_n    (urst_n),
    .full_n    (full_n),
    .term_done (term_done),
    .stop_n    (stop_n),
    .pop_x     (pop_x)
);

// File: tb/test_fifo_stall_breaker.sv
// Directed bench for fifo_stall_breaker: one task per scenario.
module test_fifo_stall_breaker;

    localparam int CNT_W = 4;
    localparam int SYNC  = 2;
    localparam int TMO   = 1 << CNT_W;

    logic bclk = 1'b0;
    logic uclk = 1'b0;
    logic brst_n = 1'b0;
    logic urst_n = 1'b0;
    logic full_n = 1'b1;
    logic term_done = 1'b0;
    logic stop_n;
    logic pop_x;

    int n_chk  = 0;
    int n_fail = 0;
    int pops   = 0;
    int bcyc   = 0;

    always #5 bclk = ~bclk;   // 100 MHz bus clock
    always #7 uclk = ~uclk;   // slower user clock

    fifo_stall_breaker #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC)) i_fifo_stall_breaker (
        .bclk(bclk), .brst_n(brst_n), .uclk(uclk), .urst_n(urst_n),
        .full_n(full_n), .term_done(term_done), .stop_n(stop_n), .pop_x(pop_x)
    );

    // Count extra-read strobes away from the user clock edge.
    always @(negedge uclk) if (urst_n && pop_x === 1'b1) pops++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bwait(input int n);
        repeat (n) @(negedge bclk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(negedge bclk) begin
        bcyc++;
        if (bcyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", bcyc, 20000);
            summary();
        end
    end

    task automatic t_reset();
        bwait(2);
        chk(stop_n === 1'b1, "R1 stop_n in reset", int'(stop_n), 1);
        chk(pop_x === 1'b0, "R1 pop_x in reset", int'(pop_x), 0);
        brst_n = 1'b1;
        urst_n = 1'b1;
        bwait(3);
        chk(stop_n === 1'b1, "R1 stop_n after reset", int'(stop_n), 1);
        chk(pops == 0, "R1 no pop after reset", pops, 0);
    endtask

    task automatic t_short_and_broken();
        int base = pops;
        full_n = 1'b0;
        bwait(TMO - 1);
        chk(stop_n === 1'b1, "R2 short run", int'(stop_n), 1);
        full_n = 1'b1;
        bwait(1);
        full_n = 1'b0;
        bwait(TMO - 1);
        full_n = 1'b1;
        bwait(20);
        chk(stop_n === 1'b1, "R2 broken run restarts count", int'(stop_n), 1);
        chk(pops == base, "R2 no pop", pops - base, 0);
    endtask

    task automatic t_release(input string req);
        term_done = 1'b1;
        bwait(1);
        term_done = 1'b0;
        chk(stop_n === 1'b1, req, int'(stop_n), 1);
    endtask

    task automatic t_long_full();
        int base = pops;
        full_n = 1'b0;
        bwait(TMO - 1);
        chk(stop_n === 1'b1, "R3 one before limit", int'(stop_n), 1);
        bwait(1);
        chk(stop_n === 1'b0, "R3 at limit", int'(stop_n), 0);
        bwait(SYNC + 10);
        chk(pops - base == 1, "R7 one extra read", pops - base, 1);
        full_n = 1'b1;
        bwait(4);
        chk(stop_n === 1'b0, "R4 held while not full", int'(stop_n), 0);
        full_n = 1'b0;
        bwait(3 * TMO);
        chk(stop_n === 1'b0, "R4 held over long full", int'(stop_n), 0);
        chk(pops - base == 1, "R9 no second pop", pops - base, 1);
        // R5: release with FIFO still full, then a re-armed timeout
        t_release("R5 release");
        bwait(TMO - 1);
        chk(stop_n === 1'b1, "R5 rearm one before limit", int'(stop_n), 1);
        bwait(1);
        chk(stop_n === 1'b0, "R5 rearm timeout", int'(stop_n), 0);
        bwait(SYNC + 10);
        chk(pops - base == 2, "R7 pop after rearm", pops - base, 2);
        full_n = 1'b1;
        t_release("R5 second release");
    endtask

    task automatic t_idle_term();
        term_done = 1'b1;
        bwait(3);
        term_done = 1'b0;
        chk(stop_n === 1'b1, "R6 idle term", int'(stop_n), 1);
        full_n = 1'b0;
        bwait(TMO - 1);
        chk(stop_n === 1'b1, "R6 count unaffected", int'(stop_n), 1);
        bwait(1);
        chk(stop_n === 1'b0, "R6 timeout exact", int'(stop_n), 0);
        full_n = 1'b1;
        bwait(SYNC + 10);
        t_release("R6 release");
    endtask

    task automatic t_drained();
        int base = pops;
        full_n = 1'b0;
        bwait(TMO);
        chk(stop_n === 1'b0, "R8 timeout", int'(stop_n), 0);
        full_n = 1'b1;
        bwait(SYNC + 12);
        chk(pops == base, "R8 pop withheld", pops - base, 0);
        chk(stop_n === 1'b0, "R4 still held", int'(stop_n), 0);
        t_release("R8 release");
    endtask

    initial begin
        t_reset();
        t_short_and_broken();
        t_long_full();
        t_idle_term();
        t_drained();
        bwait(5);
        summary();
    end

endmodule : test_fifo_stall_breaker